// File: doc/BRIEF.md
# IO Bridge Interrupt Mapper and Responder

This block is the interrupt half of one IO bus bridge. Every attached device drives four request lines, numbered 7 down to 4. The block ORs each line across all devices. It then folds lines 7 and 6 into a "high" group and lines 5 and 4 into a "low" group. Each group is steered onto one of the seven CPU priority lines (`bus_intr[7:1]`) by a 3-bit level setting. Level 1 is the most urgent, and a setting of 0 switches the group off.

Interrupt service is a two-step exchange on the backplane:

- **Identification cycle.** The CPU first asks which bridge is requesting at a given level. If this bridge drives that level, it answers with a one-hot bridge identifier.
- **Vector cycle.** The CPU then sends a vector cycle addressed to the bridge by number. The bridge settles the level first: it takes the more urgent of its two active groups. It then takes the lowest-numbered device requesting within that group, and returns that device's 18-bit vector.
- **Acknowledge.** One cycle after the vector is returned, the chosen device receives a one-cycle acknowledge pulse.

The control sequence is a four-state machine:

| State | What it does | Next state |
|-------|--------------|------------|
| `ST_IDLE` | Waits for a bus request. | `ST_IDENT` on an identification cycle that matches a level this bridge drives. `ST_VECTOR` on a vector cycle addressed here while a request is pending. Otherwise stays in `ST_IDLE`. |
| `ST_IDENT` | Presents the identifier for one cycle. | Always `ST_IDLE`. |
| `ST_VECTOR` | Presents the vector for one cycle. | Always `ST_ACK`. |
| `ST_ACK` | Pulses the selected device's acknowledge. | Always `ST_IDLE`. |

Bus requests that arrive in any state other than `ST_IDLE` are dropped.

Top module: `bridge_irq_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `rsp_data`, `dev_ack` and `bus_intr` are all zero, provided no device requests.
- R2: `bus_intr[k]` is high exactly when the high group setting equals k and any device drives line 7 (bit 4d+3) or 6 (bit 4d+2), or the low group setting equals k and any device drives line 5 (bit 4d+1) or 4 (bit 4d). Equal settings share one line.
- R3: A group whose setting is 0 drives no `bus_intr` line and is never chosen on a vector cycle.
- R4: An identification cycle has `bus_req` high and these address bits set: 32 (read), 27 (physical), 25 (IO) and 24 (identify). Bits 30 (write) and 23 (vector) must be clear. Its level is in bits 20:18. If `bus_intr` at that level is high, `rsp_valid` rises the next cycle with `rsp_data` = 1 << (17 - BRIDGE_NUM).
- R5: An identification cycle whose level is 0 or not driven by this bridge, or whose flag bits do not match R4, gives no response.
- R6: A vector cycle is decoded like R4, except that bit 23 is set and bit 24 is clear, and bits 21:18 must equal BRIDGE_NUM. If both groups are active, the one with the smaller nonzero setting is chosen. If the settings are equal, both groups are eligible.
- R7: Within the chosen level, the lowest-index device with a request in that group wins. `rsp_data` is its `dev_vec` slice, zero-extended to 36 bits, one cycle after the request.
- R8: A vector cycle naming another bridge number, or arriving when no group is active, gives no response and no acknowledge.
- R9: Exactly one cycle after a vector response, `dev_ack` carries a one-cycle one-hot pulse for the chosen device. `dev_ack` is zero otherwise.
- R10: A bus request presented while a response or acknowledge is in progress is ignored.
- R11: `rsp_valid` lasts exactly one cycle. `rsp_data` is zero whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hi_lvl | input | 3 | CPU level for request lines 7/6, 0 = off |
| cfg_lo_lvl | input | 3 | CPU level for request lines 5/4, 0 = off |
| dev_irq | input | 4*N_DEV | Device d request lines 7..4 at bits 4d+3..4d |
| dev_vec | input | 18*N_DEV | Device d vector at bits 18d+17..18d |
| bus_req | input | 1 | Backplane cycle strobe |
| bus_addr | input | 36 | Backplane address word with flag bits |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 36 | Identifier or vector |
| dev_ack | output | N_DEV | One-hot acknowledge pulse |
| bus_intr | output | 7 | CPU priority request lines 7..1 |

## Verification
Two kinds of error stay hidden for a while:

- **Stuck state machine.** The state machine staying out of `ST_IDLE` shows up only at the next request, when the response is silently missing.
- **Wrong latched selection.** A wrongly latched device index shows up two cycles after the vector cycle, as a misplaced `dev_ack` bit. The vector word one cycle earlier may already be wrong.

A reference model compares `rsp_valid`, `rsp_data`, `dev_ack` and `bus_intr` on every clock. Any divergence is therefore caught in the cycle it appears.

// File: rtl/bridge_irq_pkg.sv
package bridge_irq_pkg;
    localparam int LINES   = 4;
    localparam int VEC_W   = 18;
    localparam int DATA_W  = 36;
    localparam int ADDR_W  = 36;
    localparam int LVL_W   = 3;
    localparam int BRN_W   = 4;
    // flag bit positions in the address word
    localparam int FB_READ  = 32;
    localparam int FB_WRITE = 30;
    localparam int FB_PHYS  = 27;
    localparam int FB_IO    = 25;
    localparam int FB_IDENT = 24;
    localparam int FB_VECT  = 23;
    localparam int FLD_LSB  = 18;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IDENT,
        ST_VECTOR,
        ST_ACK
    } irq_state_e;
endpackage

// File: rtl/bridge_irq_decode.sv
module bridge_irq_decode
    import bridge_irq_pkg::*;
(
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              is_ident,
    output logic              is_vect,
    output logic [LVL_W-1:0]  req_lvl,
    output logic [BRN_W-1:0]  req_brn
);
    logic base_ok;

    always_comb begin
        base_ok  = bus_req && bus_addr[FB_READ] && !bus_addr[FB_WRITE]
                   && bus_addr[FB_PHYS] && bus_addr[FB_IO];
        is_ident = base_ok && bus_addr[FB_IDENT] && !bus_addr[FB_VECT];
        is_vect  = base_ok && bus_addr[FB_VECT] && !bus_addr[FB_IDENT];
        req_lvl  = bus_addr[FLD_LSB +: LVL_W];
        req_brn  = bus_addr[FLD_LSB +: BRN_W];
    end
endmodule

// File: rtl/bridge_irq_map.sv
module bridge_irq_map
    import bridge_irq_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic [LINES*N_DEV-1:0] dev_irq,
    input  logic [LVL_W-1:0]       cfg_hi_lvl,
    input  logic [LVL_W-1:0]       cfg_lo_lvl,
    output logic [7:1]             bus_intr,
    output logic                   use_hi,
    output logic                   use_lo
);
    logic [N_DEV-1:0] hi_dev;
    logic [N_DEV-1:0] lo_dev;
    logic             hi_on;
    logic             lo_on;

    for (genvar d = 0; d < N_DEV; d++) begin : g_or
        assign hi_dev[d] = dev_irq[LINES*d+3] | dev_irq[LINES*d+2];
        assign lo_dev[d] = dev_irq[LINES*d+1] | dev_irq[LINES*d];
    end

    always_comb begin
        hi_on = (|hi_dev) && (cfg_hi_lvl != '0);
        lo_on = (|lo_dev) && (cfg_lo_lvl != '0);
        for (int k = 1; k <= 7; k++) begin
            bus_intr[k] = (hi_on && cfg_hi_lvl == LVL_W'(k))
                       || (lo_on && cfg_lo_lvl == LVL_W'(k));
        end
        // smaller level number is the more urgent one
        use_hi = hi_on && (!lo_on || cfg_hi_lvl <= cfg_lo_lvl);
        use_lo = lo_on && (!hi_on || cfg_lo_lvl <= cfg_hi_lvl);
    end
endmodule

// File: rtl/bridge_irq_pick.sv
module bridge_irq_pick
    import bridge_irq_pkg::*;
#(
    parameter int N_DEV = 4,
    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic [LINES*N_DEV-1:0] dev_irq,
    input  logic [VEC_W*N_DEV-1:0] dev_vec,
    input  logic                   use_hi,
    input  logic                   use_lo,
    output logic                   found,
    output logic [IDX_W-1:0]       win_idx,
    output logic [VEC_W-1:0]       win_vec
);
    logic [N_DEV-1:0] elig;

    for (genvar d = 0; d < N_DEV; d++) begin : g_elig
        assign elig[d] = (use_hi && (dev_irq[LINES*d+3] | dev_irq[LINES*d+2]))
                      || (use_lo && (dev_irq[LINES*d+1] | dev_irq[LINES*d]));
    end

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int d = N_DEV - 1; d >= 0; d--) begin
            if (elig[d]) begin
                found   = 1'b1;
                win_idx = IDX_W'(d);
            end
        end
        win_vec = '0;
        for (int d = 0; d < N_DEV; d++) begin
            if (win_idx == IDX_W'(d)) win_vec = dev_vec[VEC_W*d +: VEC_W];
        end
    end
endmodule

// File: rtl/bridge_irq_unit.sv
module bridge_irq_unit
    import bridge_irq_pkg::*;
#(
    parameter int N_DEV      = 4,
    parameter int BRIDGE_NUM = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LVL_W-1:0]       cfg_hi_lvl,
    input  logic [LVL_W-1:0]       cfg_lo_lvl,
    input  logic [LINES*N_DEV-1:0] dev_irq,
    input  logic [VEC_W*N_DEV-1:0] dev_vec,
    input  logic                   bus_req,
    input  logic [ADDR_W-1:0]      bus_addr,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic [N_DEV-1:0]       dev_ack,
    output logic [7:1]             bus_intr
);
    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam logic [DATA_W-1:0] ID_WORD = DATA_W'(1) << (17 - BRIDGE_NUM);

    irq_state_e        state_q, state_d;
    logic [DATA_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;

    logic             is_ident, is_vect;
    logic [LVL_W-1:0] req_lvl;
    logic [BRN_W-1:0] req_brn;
    logic             use_hi, use_lo, found;
    logic [IDX_W-1:0] win_idx;
    logic [VEC_W-1:0] win_vec;
    logic             ident_hit, vect_hit;

    bridge_irq_decode u_decode (
        .bus_req (bus_req),
        .bus_addr(bus_addr),
        .is_ident(is_ident),
        .is_vect (is_vect),
        .req_lvl (req_lvl),
        .req_brn (req_brn)
    );

    bridge_irq_map #(.N_DEV(N_DEV)) u_map (
        .dev_irq   (dev_irq),
        .cfg_hi_lvl(cfg_hi_lvl),
        .cfg_lo_lvl(cfg_lo_lvl),
        .bus_intr  (bus_intr),
        .use_hi    (use_hi),
        .use_lo    (use_lo)
    );

    bridge_irq_pick #(.N_DEV(N_DEV)) u_pick (
        .dev_irq(dev_irq),
        .dev_vec(dev_vec),
        .use_hi (use_hi),
        .use_lo (use_lo),
        .found  (found),
        .win_idx(win_idx),
        .win_vec(win_vec)
    );

    always_comb begin
        ident_hit = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            if (req_lvl == LVL_W'(k) && bus_intr[k]) ident_hit = is_ident;
        end
        vect_hit = is_vect && found && (req_brn == BRN_W'(BRIDGE_NUM));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ident_hit)     state_d = ST_IDENT;
                else if (vect_hit) state_d = ST_VECTOR;
            end
            ST_IDENT:  state_d = ST_IDLE;
            ST_VECTOR: state_d = ST_ACK;
            ST_ACK:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (state_q == ST_IDLE) begin
            if (ident_hit) begin
                word_q <= ID_WORD;
            end else if (vect_hit) begin
                word_q <= DATA_W'(win_vec);
                idx_q  <= win_idx;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
        dev_ack   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_IDENT, ST_VECTOR: begin
                rsp_valid = 1'b1;
                rsp_data  = word_q;
            end
            ST_ACK: dev_ack = N_DEV'(1) << idx_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/bridge_irq_unit_chk.sv
module bridge_irq_unit_chk #(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cfg_hi_lvl,
    input logic [2:0]       cfg_lo_lvl,
    input logic             bus_req,
    input logic             rsp_valid,
    input logic [N_DEV-1:0] dev_ack,
    input logic [7:1]       bus_intr
);
    // R11
    resp_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R9
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_ack));
    // R9
    ack_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_ack != '0) |-> $past(rsp_valid));
    // R9
    ack_rsp_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && dev_ack != '0));
    // R10
    rsp_from_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(bus_req));
    // R3
    groups_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_hi_lvl == 3'd0 && cfg_lo_lvl == 3'd0) |-> bus_intr == '0);
endmodule

bind bridge_irq_unit bridge_irq_unit_chk #(.N_DEV(N_DEV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_hi_lvl(cfg_hi_lvl),
    .cfg_lo_lvl(cfg_lo_lvl),
    .bus_req   (bus_req),
    .rsp_valid (rsp_valid),
    .dev_ack   (dev_ack),
    .bus_intr  (bus_intr)
);

// File: tb/test_bridge_irq_unit.sv
module test_bridge_irq_unit;
    localparam int NDV = 4;
    localparam int BRN = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        cfg_hi_lvl = 3'd0;
    logic [2:0]        cfg_lo_lvl = 3'd0;
    logic [4*NDV-1:0]  dev_irq = '0;
    logic [18*NDV-1:0] dev_vec = '0;
    logic              bus_req = 1'b0;
    logic [35:0]       bus_addr = '0;
    logic              rsp_valid;
    logic [35:0]       rsp_data;
    logic [NDV-1:0]    dev_ack;
    logic [7:1]        bus_intr;

    bridge_irq_unit #(.N_DEV(NDV), .BRIDGE_NUM(BRN)) i_bridge_irq_unit (
        .clk(clk), .rst(rst), .cfg_hi_lvl(cfg_hi_lvl), .cfg_lo_lvl(cfg_lo_lvl),
        .dev_irq(dev_irq), .dev_vec(dev_vec), .bus_req(bus_req), .bus_addr(bus_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dev_ack(dev_ack), .bus_intr(bus_intr)
    );

    always #10 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string tag = "R1";

    task automatic check(bit ok, string what, logic [35:0] act, logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] mk(bit rd, bit wr, bit ph, bit io, bit idn, bit vc,
                                       logic [3:0] fld);
        logic [35:0] a;
        a = 36'h0_0002_A5A5;
        a[32] = rd; a[30] = wr; a[27] = ph; a[25] = io; a[24] = idn; a[23] = vc;
        a[21:18] = fld;
        return a;
    endfunction

    function automatic logic [7:1] m_intr(logic [4*NDV-1:0] irq, logic [2:0] hi, logic [2:0] lo);
        logic [7:1] r;
        bit ha, la;
        ha = 0; la = 0;
        for (int d = 0; d < NDV; d++) begin
            if (irq[4*d+3] || irq[4*d+2]) ha = 1;
            if (irq[4*d+1] || irq[4*d])   la = 1;
        end
        r = '0;
        for (int k = 1; k <= 7; k++)
            if ((ha && hi == 3'(k)) || (la && lo == 3'(k))) r[k] = 1'b1;
        return r;
    endfunction

    function automatic int m_pick(logic [4*NDV-1:0] irq, logic [2:0] hi, logic [2:0] lo);
        bit ha, la, uh, ul;
        ha = 0; la = 0;
        for (int d = 0; d < NDV; d++) begin
            if (irq[4*d+3] || irq[4*d+2]) ha = 1;
            if (irq[4*d+1] || irq[4*d])   la = 1;
        end
        ha = ha && hi != 0;
        la = la && lo != 0;
        uh = ha && (!la || hi <= lo);
        ul = la && (!ha || lo <= hi);
        for (int d = 0; d < NDV; d++)
            if ((uh && (irq[4*d+3] || irq[4*d+2])) || (ul && (irq[4*d+1] || irq[4*d])))
                return d;
        return -1;
    endfunction

    // reference model: 0 idle, 1 identifier out, 2 vector out, 3 acknowledge
    int          ms = 0;
    int          m_idx = 0;
    logic        e_rv = 0;
    logic [35:0] e_data = '0;
    logic [3:0]  e_ack = '0;

    always @(posedge clk) begin
        logic [7:1] it;
        logic [2:0] lv;
        bit base, idn, vc;
        int p;
        cycles++;
        if (rst) begin
            ms = 0; e_rv = 0; e_data = '0; e_ack = '0;
        end else begin
            it   = m_intr(dev_irq, cfg_hi_lvl, cfg_lo_lvl);
            base = bus_req && bus_addr[32] && !bus_addr[30] && bus_addr[27] && bus_addr[25];
            idn  = base && bus_addr[24] && !bus_addr[23];
            vc   = base && bus_addr[23] && !bus_addr[24];
            lv   = bus_addr[20:18];
            p    = m_pick(dev_irq, cfg_hi_lvl, cfg_lo_lvl);
            e_ack = '0; e_rv = 0; e_data = '0;
            case (ms)
                0: begin
                    if (idn && lv != 0 && it[lv]) begin
                        ms = 1; e_rv = 1; e_data = 36'd1 << (17 - BRN);
                    end else if (vc && bus_addr[21:18] == 4'(BRN) && p >= 0) begin
                        ms = 2; e_rv = 1; m_idx = p;
                        e_data = {18'd0, dev_vec[18*p +: 18]};
                    end
                end
                1: ms = 0;
                2: begin ms = 3; e_ack = 4'(1) << m_idx; end
                default: ms = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            check(rsp_valid == e_rv, "rsp_valid", 36'(rsp_valid), 36'(e_rv));
            check(rsp_data == e_data, "rsp_data", rsp_data, e_data);
            check(dev_ack == e_ack, "dev_ack(R9)", 36'(dev_ack), 36'(e_ack));
            check(bus_intr == m_intr(dev_irq, cfg_hi_lvl, cfg_lo_lvl), "bus_intr(R2)",
                  36'(bus_intr), 36'(m_intr(dev_irq, cfg_hi_lvl, cfg_lo_lvl)));
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(bit rq, logic [35:0] a);
        bus_req = rq; bus_addr = a;
        @(posedge clk); #2;
        bus_req = 0; bus_addr = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0);
    endtask

    function automatic logic [35:0] idq(logic [2:0] l);
        return mk(1, 0, 1, 1, 1, 0, {1'b0, l});
    endfunction

    function automatic logic [35:0] vq(logic [3:0] b);
        return mk(1, 0, 1, 1, 0, 1, b);
    endfunction

    initial begin
        for (int d = 0; d < NDV; d++) dev_vec[18*d +: 18] = 18'(18'o000100 + 4 * (d + 1));
        tag = "R1";
        repeat (3) @(posedge clk);
        #2 rst = 0;
        idle(2);

        tag = "R2";
        cfg_hi_lvl = 3; cfg_lo_lvl = 5;
        dev_irq[4*1+2] = 1; idle(2);
        dev_irq[4*3+0] = 1; idle(2);
        cfg_hi_lvl = 4; cfg_lo_lvl = 4; idle(2);

        tag = "R3";
        dev_irq = '0; dev_irq[4*0+3] = 1;
        cfg_hi_lvl = 0; cfg_lo_lvl = 2; idle(2);
        step(1, vq(4'(BRN))); idle(3);
        step(1, idq(3'd2)); idle(3);

        tag = "R4";
        cfg_hi_lvl = 3; idle(1);
        step(1, idq(3'd3)); idle(3);

        tag = "R5";
        step(1, idq(3'd5)); idle(2);
        step(1, idq(3'd0)); idle(2);
        step(1, mk(1, 1, 1, 1, 1, 0, 4'd3)); idle(2);
        step(1, mk(1, 0, 0, 1, 1, 0, 4'd3)); idle(2);

        tag = "R6";
        dev_irq = '0; dev_irq[4*0+3] = 1; dev_irq[4*2+1] = 1;
        cfg_hi_lvl = 6; cfg_lo_lvl = 2; idle(1);
        step(1, vq(4'(BRN))); idle(3);
        cfg_hi_lvl = 2; cfg_lo_lvl = 6; idle(1);
        step(1, vq(4'(BRN))); idle(3);
        dev_irq[4*0+3] = 0; dev_irq[4*1+0] = 1; cfg_hi_lvl = 4; cfg_lo_lvl = 4; idle(1);
        step(1, vq(4'(BRN))); idle(3);

        tag = "R7";
        dev_irq = '0; dev_irq[4*3+2] = 1; dev_irq[4*1+3] = 1; dev_irq[4*2+2] = 1;
        cfg_hi_lvl = 1; cfg_lo_lvl = 0; idle(1);
        step(1, vq(4'(BRN))); idle(3);

        tag = "R8";
        step(1, vq(4'(BRN + 1))); idle(3);
        dev_irq = '0; idle(1);
        step(1, vq(4'(BRN))); idle(3);

        tag = "R10";
        dev_irq[4*2+0] = 1; cfg_lo_lvl = 5; idle(1);
        step(1, vq(4'(BRN))); step(1, idq(3'd5)); step(1, vq(4'(BRN))); idle(3);
        step(1, idq(3'd5)); step(1, idq(3'd5)); idle(3);

        tag = "R11";
        for (int i = 0; i < 600; i++) begin
            if (i % 8 == 0) begin
                dev_irq = 16'($urandom) & 16'($urandom);
                cfg_hi_lvl = 3'($urandom); cfg_lo_lvl = 3'($urandom);
            end
            case ($urandom % 4)
                0: step(1, idq(3'($urandom)));
                1: step(1, vq(4'($urandom % 5)));
                2: step(1, mk(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                              1'($urandom), 1'($urandom), 4'($urandom)));
                default: step(0, '0);
            endcase
        end
        idle(3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule